// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block turns one register-access request into the ordered series of byte commands that a byte-level I2C master needs to complete a combined-format transaction. A request names a 7-bit device address, an 8-bit register index, a direction and, for writes, one data byte. The sequencer hands each byte command to the master over a valid/done handshake and holds it until the master reports the byte finished. After each transmitted byte it checks the acknowledge the master observed. When the transaction ends, it reports either success, with the fetched byte for reads, or failure.

A write costs three byte commands. A read costs four, because the direction changes: the register index is sent first, then a repeated start re-addresses the device for reading. If any transmitted byte is not acknowledged, the sequencer stops at that byte. If that byte did not already carry a stop, it sends a stop-only command so that the bus is released. Bit timing, the prescaler and clock stretching belong to the downstream master.

Top module: `i2c_reg_seq`

## Requirements
- R1: A write issues exactly three commands, in this order. First: start+transmit of the address byte `{dev, 0}`. Second: transmit of the register index. Third: transmit+stop of the data byte. It then pulses `done`.
- R2: A read issues four commands, in this order. First: start+transmit of `{dev, 0}`. Second: transmit of the index. Third: start+transmit of `{dev, 1}`, the repeated start. Fourth: a receive command.
- R3: The receive command carries the read, stop and NACK flags together with no transmit flag. The byte returned by the master for it appears on `rdata` in the same cycle as the `done` pulse.
- R4: `cmd_rxack` = 1 after a transmit command means "not acknowledged". The sequencer then issues no further byte of the transaction. If the refused command had no stop, exactly one stop-only command (stop=1, every other flag 0) follows. `err` pulses in either case.
- R5: `cmd_txbyte` is loaded at least one cycle before `cmd_valid` rises and stays unchanged while `cmd_valid` is high.
- R6: `cmd_valid` and the command flags stay high until `cmd_done`. `cmd_valid` is low for at least one cycle between two commands.
- R7: A request presented while `en` is low is not accepted: `busy` stays low and no command is issued.
- R8: `busy` rises the cycle after acceptance and falls in the same cycle that `done` or `err` rises. Requests presented while `busy` is high are ignored and leave no trace in the command stream.
- R9: `done` and `err` are one-cycle pulses and never high together.
- R10: `rdata` changes only together with a `done` pulse of a successful read. A write or a failed transaction leaves it unchanged.
- R11: After reset, `busy`, `done`, `err` and `cmd_valid` are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Byte master is enabled; requests are accepted only while high |
| req_valid | input | 1 | Request strobe, taken when idle and enabled |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_dev | input | 7 | Device address |
| req_index | input | 8 | Register index |
| req_wdata | input | 8 | Write data byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: transaction succeeded |
| err | output | 1 | One-cycle pulse: transaction aborted on missing acknowledge |
| rdata | output | 8 | Byte from the last successful read |
| cmd_valid | output | 1 | Byte command presented to the master |
| cmd_start | output | 1 | Command flag: generate (repeated) start first |
| cmd_stop | output | 1 | Command flag: generate stop afterwards |
| cmd_wr | output | 1 | Command flag: transmit `cmd_txbyte` |
| cmd_rd | output | 1 | Command flag: receive one byte |
| cmd_nack | output | 1 | Command flag: answer the received byte with NACK |
| cmd_txbyte | output | 8 | Byte to transmit |
| cmd_done | input | 1 | One-cycle pulse from the master: command finished |
| cmd_rxack | input | 1 | With `cmd_done`: 1 = slave did not acknowledge |
| cmd_rxbyte | input | 8 | With `cmd_done`: received byte |

## Verification
The bench refuses the acknowledge at several positions.

- Refusing the address byte, the index byte or the read-direction address byte shows whether a design sends its recovery stop. A design that skips that stop would leave the bus held.
- Refusing the final write byte shows whether the design knows that byte already carried the stop. A design that does not would send a second stop.
- A refused read exposes a design that updates `rdata` anyway: the old value would be replaced.

Requests pulsed in the middle of a transaction or while `en` is low expose a design that re-arms too early: extra commands would appear in the stream. Reads and writes to the extreme address and index values expose a design that forgets the direction bit, or clears it at the repeated start.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    ST_ADDR_W = 3'd0,
    ST_INDEX  = 3'd1,
    ST_WDATA  = 3'd2,
    ST_ADDR_R = 3'd3,
    ST_RDATA  = 3'd4,
    ST_STOP   = 3'd5
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic wr;
    logic rd;
    logic nack;
  } flags_t;

  // Command flags that belong to each step of a transaction.
  function automatic flags_t step_flags(input step_e s);
    flags_t f;
    f = '0;
    case (s)
      ST_ADDR_W, ST_ADDR_R: begin f.start = 1'b1; f.wr = 1'b1; end
      ST_INDEX:             f.wr = 1'b1;
      ST_WDATA:             begin f.wr = 1'b1; f.stop = 1'b1; end
      ST_RDATA:             begin f.rd = 1'b1; f.stop = 1'b1; f.nack = 1'b1; end
      ST_STOP:              f.stop = 1'b1;
      default:              f = '0;
    endcase
    return f;
  endfunction

  // Successor of a step on the normal (acknowledged) path.
  function automatic step_e next_step(input step_e s, input logic is_read);
    case (s)
      ST_ADDR_W: return ST_INDEX;
      ST_INDEX:  return is_read ? ST_ADDR_R : ST_WDATA;
      ST_ADDR_R: return ST_RDATA;
      default:   return ST_STOP;
    endcase
  endfunction

  // Steps after which the transaction is over.
  function automatic logic step_last(input step_e s);
    return (s == ST_WDATA) || (s == ST_RDATA) || (s == ST_STOP);
  endfunction

endpackage

// File: rtl/i2c_seq_ctrl.sv
`timescale 1ns/1ps
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  req_valid,
  input  logic  req_read,
  input  logic  cmd_done,
  input  logic  cmd_rxack,
  output logic  accept,
  output logic  load,
  output step_e load_step,
  output logic  cmd_valid,
  output logic  busy,
  output logic  nack_seen,
  output logic  fin_ok,
  output logic  fin_err,
  output logic  capture_rd
);

  phase_e phase_q;
  step_e  step_q;
  logic   read_q;
  flags_t cur;
  logic   advance, last, abort_go, move_on, clean_end;

  assign cur       = step_flags(step_q);
  assign last      = step_last(step_q);
  assign accept    = (phase_q == PH_IDLE) && req_valid && en;
  assign cmd_valid = (phase_q == PH_WAIT);
  assign busy      = (phase_q != PH_IDLE);
  assign advance   = cmd_valid && cmd_done;
  assign nack_seen = advance && cur.wr && cmd_rxack;

  always_comb begin
    abort_go   = nack_seen && !cur.stop;
    move_on    = advance && !nack_seen && !last;
    clean_end  = advance && !nack_seen && last;
    fin_ok     = clean_end && (step_q != ST_STOP);
    fin_err    = (nack_seen && cur.stop) || (clean_end && (step_q == ST_STOP));
    capture_rd = fin_ok && (step_q == ST_RDATA);
    load       = accept || abort_go || move_on;
    if (accept)        load_step = ST_ADDR_W;
    else if (abort_go) load_step = ST_STOP;
    else               load_step = next_step(step_q, read_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= ST_ADDR_W;
      read_q  <= 1'b0;
    end else begin
      if (accept) read_q <= req_read;
      if (load) begin
        step_q  <= load_step;
        phase_q <= PH_LOAD;
      end else if (phase_q == PH_LOAD) begin
        phase_q <= PH_WAIT;
      end else if (fin_ok || fin_err) begin
        phase_q <= PH_IDLE;
      end
    end
  end

endmodule

// File: rtl/i2c_seq_cmd_reg.sv
`timescale 1ns/1ps
module i2c_seq_cmd_reg
  import i2c_seq_pkg::*;
#(
  parameter int DEV_W  = 7,
  parameter int BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [BYTE_W-1:0] req_index,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              load,
  input  step_e             load_step,
  output flags_t            flags_q,
  output logic [BYTE_W-1:0] tx_q
);

  logic [DEV_W-1:0]  dev_q, dev_src;
  logic [BYTE_W-1:0] idx_q, idx_src, wd_q, wd_src;

  // Byte placed on the transmit lane for a step; zero when nothing is sent.
  function automatic logic [BYTE_W-1:0] pick_byte(
    input step_e             s,
    input logic [DEV_W-1:0]  dev,
    input logic [BYTE_W-1:0] idx,
    input logic [BYTE_W-1:0] wd
  );
    case (s)
      ST_ADDR_W: return {dev, 1'b0};
      ST_ADDR_R: return {dev, 1'b1};
      ST_INDEX:  return idx;
      ST_WDATA:  return wd;
      default:   return '0;
    endcase
  endfunction

  assign dev_src = accept ? req_dev   : dev_q;
  assign idx_src = accept ? req_index : idx_q;
  assign wd_src  = accept ? req_wdata : wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q   <= '0;
      idx_q   <= '0;
      wd_q    <= '0;
      flags_q <= '0;
      tx_q    <= '0;
    end else begin
      if (accept) begin
        dev_q <= req_dev;
        idx_q <= req_index;
        wd_q  <= req_wdata;
      end
      if (load) begin
        flags_q <= step_flags(load_step);
        tx_q    <= pick_byte(load_step, dev_src, idx_src, wd_src);
      end
    end
  end

endmodule

// File: rtl/i2c_seq_result.sv
`timescale 1ns/1ps
module i2c_seq_result #(
  parameter int BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin_ok,
  input  logic              fin_err,
  input  logic              capture_rd,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              done,
  output logic              err,
  output logic [BYTE_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      done <= fin_ok;
      err  <= fin_err;
      if (capture_rd) rdata <= rx_byte;
    end
  end

endmodule

// File: rtl/i2c_reg_seq.sv
`timescale 1ns/1ps
module i2c_reg_seq
  import i2c_seq_pkg::*;
#(
  parameter int DEV_W  = 7,
  parameter int BYTE_W = DEV_W + 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [BYTE_W-1:0] req_index,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [BYTE_W-1:0] rdata,
  output logic              cmd_valid,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_wr,
  output logic              cmd_rd,
  output logic              cmd_nack,
  output logic [BYTE_W-1:0] cmd_txbyte,
  input  logic              cmd_done,
  input  logic              cmd_rxack,
  input  logic [BYTE_W-1:0] cmd_rxbyte
);

  // Internal events, named so the checker can observe them.
  logic   accept, load, nack_seen, fin_ok, fin_err, capture_rd;
  step_e  load_step;
  flags_t flags_q;

  i2c_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .req_valid  (req_valid),
    .req_read   (req_read),
    .cmd_done   (cmd_done),
    .cmd_rxack  (cmd_rxack),
    .accept     (accept),
    .load       (load),
    .load_step  (load_step),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .nack_seen  (nack_seen),
    .fin_ok     (fin_ok),
    .fin_err    (fin_err),
    .capture_rd (capture_rd)
  );

  i2c_seq_cmd_reg #(.DEV_W(DEV_W), .BYTE_W(BYTE_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_dev   (req_dev),
    .req_index (req_index),
    .req_wdata (req_wdata),
    .load      (load),
    .load_step (load_step),
    .flags_q   (flags_q),
    .tx_q      (cmd_txbyte)
  );

  i2c_seq_result #(.BYTE_W(BYTE_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .fin_ok     (fin_ok),
    .fin_err    (fin_err),
    .capture_rd (capture_rd),
    .rx_byte    (cmd_rxbyte),
    .done       (done),
    .err        (err),
    .rdata      (rdata)
  );

  assign cmd_start = flags_q.start;
  assign cmd_stop  = flags_q.stop;
  assign cmd_wr    = flags_q.wr;
  assign cmd_rd    = flags_q.rd;
  assign cmd_nack  = flags_q.nack;

endmodule

// File: rtl/i2c_reg_seq_chk.sv
`timescale 1ns/1ps
module i2c_reg_seq_chk #(
  parameter int BYTE_W = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [BYTE_W-1:0] rdata,
  input logic              cmd_valid,
  input logic              cmd_start,
  input logic              cmd_stop,
  input logic              cmd_wr,
  input logic              cmd_rd,
  input logic              cmd_nack,
  input logic [BYTE_W-1:0] cmd_txbyte,
  input logic              cmd_done,
  input logic              nack_seen
);

  assert_repeat_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_start |-> cmd_wr && !cmd_stop && !cmd_rd);

  assert_read_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_rd |-> cmd_stop && cmd_nack && !cmd_wr && !cmd_start);

  assert_nack_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen && cmd_stop |=> err && !busy);

  assert_nack_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen && !cmd_stop |=> busy && !err && !done);

  assert_tx_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $stable(cmd_txbyte));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && $past(cmd_valid) |-> $stable(cmd_txbyte));

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable({cmd_start, cmd_stop, cmd_wr, cmd_rd, cmd_nack}));

  assert_cmd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_done |=> !cmd_valid);

  assert_en_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en) && $past(req_valid));

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done || err);

  assert_cmd_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

endmodule

bind i2c_reg_seq i2c_reg_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .rdata      (rdata),
  .cmd_valid  (cmd_valid),
  .cmd_start  (cmd_start),
  .cmd_stop   (cmd_stop),
  .cmd_wr     (cmd_wr),
  .cmd_rd     (cmd_rd),
  .cmd_nack   (cmd_nack),
  .cmd_txbyte (cmd_txbyte),
  .cmd_done   (cmd_done),
  .nack_seen  (nack_seen)
);

// File: tb/i2c_reg_seq_test.sv
`timescale 1ns/1ps
module i2c_reg_seq_test;

  localparam int LAT = 3;

  // flag packing used by the bench: {start, stop, wr, rd, nack}
  localparam logic [4:0] F_ADDR  = 5'b10100;
  localparam logic [4:0] F_INDEX = 5'b00100;
  localparam logic [4:0] F_WDATA = 5'b01100;
  localparam logic [4:0] F_RDATA = 5'b01011;
  localparam logic [4:0] F_STOP  = 5'b01000;

  typedef struct {
    logic [4:0] fl;
    logic [7:0] b;
    bit         chk_b;
    string      tag;
  } beat_t;

  typedef struct {
    bit         is_err;
    logic [7:0] rd;
    string      tag;
  } res_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_read = 1'b0;
  logic [6:0] req_dev = '0;
  logic [7:0] req_index = '0;
  logic [7:0] req_wdata = '0;
  logic       busy, done, err;
  logic [7:0] rdata;
  logic       cmd_valid, cmd_start, cmd_stop, cmd_wr, cmd_rd, cmd_nack;
  logic [7:0] cmd_txbyte;
  logic       cmd_done = 1'b0;
  logic       cmd_rxack = 1'b0;
  logic [7:0] cmd_rxbyte = '0;

  int checks = 0;
  int fails  = 0;
  beat_t beat_q[$];
  res_t  res_q[$];
  int    resp_nack_at = 0;
  int    resp_cnt = 0;
  logic [7:0] model_rdata = 8'h00;

  always #2.5 clk = ~clk;

  i2c_reg_seq uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .req_valid(req_valid), .req_read(req_read), .req_dev(req_dev),
    .req_index(req_index), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_nack(cmd_nack),
    .cmd_txbyte(cmd_txbyte), .cmd_done(cmd_done), .cmd_rxack(cmd_rxack),
    .cmd_rxbyte(cmd_rxbyte)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor for the command side: models the byte master and scores every command.
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [4:0] fl;
        logic [7:0] tx;
        beat_t e;
        fl = {cmd_start, cmd_stop, cmd_wr, cmd_rd, cmd_nack};
        tx = cmd_txbyte;
        resp_cnt++;
        if (beat_q.size() == 0) begin
          check(1'b0, "R8", "unexpected command", {19'd0, fl, tx}, 32'd0);
        end else begin
          e = beat_q.pop_front();
          check(fl == e.fl, e.tag, "command flags", {27'd0, fl}, {27'd0, e.fl});
          if (e.chk_b)
            check(tx == e.b, e.tag, "transmit byte", {24'd0, tx}, {24'd0, e.b});
        end
        repeat (LAT) @(negedge clk);
        check(cmd_valid && cmd_txbyte == tx, "R5", "command held until done",
              {23'd0, cmd_valid, cmd_txbyte}, {23'd1, tx});
        cmd_rxack = (resp_cnt == resp_nack_at);
        cmd_done  = 1'b1;
        @(negedge clk);
        cmd_done  = 1'b0;
        cmd_rxack = 1'b0;
      end
    end
  end

  // Monitor for the result side.
  always @(negedge clk) begin
    if (rst_n && (done || err)) begin
      if (res_q.size() == 0) begin
        check(1'b0, "R9", "unexpected result pulse", {30'd0, done, err}, 32'd0);
      end else begin
        res_t r;
        r = res_q.pop_front();
        check(err == r.is_err && done == !r.is_err, r.tag, "done/err",
              {30'd0, done, err}, {30'd0, !r.is_err, r.is_err});
        check(rdata == r.rd, "R10", "rdata at result", {24'd0, rdata}, {24'd0, r.rd});
      end
    end
  end

  // Driver: builds the expected command stream and result, then sends the request.
  task automatic run_txn(input bit rd, input logic [6:0] dev, input logic [7:0] idx,
                         input logic [7:0] wd, input logic [7:0] rx, input int nack_at,
                         input bit poke, input string tag);
    beat_t seq[$];
    res_t  r;
    int    n;
    seq.push_back('{F_ADDR, {dev, 1'b0}, 1'b1, tag});
    seq.push_back('{F_INDEX, idx, 1'b1, tag});
    if (rd) begin
      seq.push_back('{F_ADDR, {dev, 1'b1}, 1'b1, "R2"});
      seq.push_back('{F_RDATA, 8'h00, 1'b0, "R3"});
    end else begin
      seq.push_back('{F_WDATA, wd, 1'b1, tag});
    end
    n = (nack_at > 0) ? nack_at : seq.size();
    for (int i = 0; i < n; i++) beat_q.push_back(seq[i]);
    if (nack_at > 0 && !seq[nack_at-1].fl[3])
      beat_q.push_back('{F_STOP, 8'h00, 1'b0, "R4"});
    if (nack_at == 0 && rd) model_rdata = rx;
    r.is_err = (nack_at > 0);
    r.rd     = model_rdata;
    r.tag    = (nack_at > 0) ? "R4" : tag;
    res_q.push_back(r);

    resp_cnt     = 0;
    resp_nack_at = nack_at;
    cmd_rxbyte   = rx;
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_dev = dev; req_index = idx; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R8", "busy after acceptance", {31'd0, busy}, 32'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b1, "R8", "busy during transaction", {31'd0, busy}, 32'd1);
      req_valid = 1'b1; req_read = 1'b0; req_dev = 7'h01; req_index = 8'h02; req_wdata = 8'h03;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (res_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(beat_q.size() == 0, tag, "all expected commands seen",
          beat_q.size(), 32'd0);
    check(busy == 1'b0 && cmd_valid == 1'b0, "R8", "idle after result",
          {30'd0, busy, cmd_valid}, 32'd0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && err == 0 && cmd_valid == 0 && rdata == 0,
          "R11", "reset state", {27'd0, busy, done, err, cmd_valid, |rdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && cmd_valid == 0, "R11", "idle after reset",
          {30'd0, busy, cmd_valid}, 32'd0);

    run_txn(1'b0, 7'h50, 8'h11, 8'hA5, 8'h00, 0, 1'b0, "R1");
    run_txn(1'b1, 7'h50, 8'h12, 8'h00, 8'h3C, 0, 1'b0, "R3");
    run_txn(1'b0, 7'h50, 8'h13, 8'h77, 8'h00, 1, 1'b0, "R4");
    run_txn(1'b0, 7'h22, 8'h40, 8'h99, 8'h00, 3, 1'b0, "R4");
    run_txn(1'b1, 7'h22, 8'h41, 8'h00, 8'hEE, 3, 1'b0, "R4");
    run_txn(1'b1, 7'h22, 8'h42, 8'h00, 8'hDD, 2, 1'b0, "R4");
    run_txn(1'b1, 7'h7F, 8'hFF, 8'h00, 8'h81, 0, 1'b1, "R2");
    run_txn(1'b0, 7'h00, 8'h00, 8'h5A, 8'h00, 0, 1'b1, "R1");

    // R7: requests while the master is disabled are not taken.
    en = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'b1; req_dev = 7'h33; req_index = 8'h44;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(busy == 1'b0 && cmd_valid == 1'b0, "R7", "request ignored while disabled",
            {30'd0, busy, cmd_valid}, 32'd0);
    end
    req_valid = 1'b0;
    en = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && rdata == model_rdata, "R7", "no trace of disabled request",
          {23'd0, busy, rdata}, {24'd0, model_rdata});

    run_txn(1'b1, 7'h15, 8'h80, 8'h00, 8'h01, 0, 1'b0, "R3");
    finish_run();
  end

endmodule